// File: doc/BRIEF.md
# Dual-Mode Bit-Serial Output Formatter

This block sits at the output of one downconverter channel. It takes filtered, decimated complex baseband words and sends them out on four bit-serial lines, one bit time per clock, most significant bit first. A frame-mark output goes with the serial data so that a receiver can find where each word starts. Parallel words come in with a single-cycle valid strobe. A one-entry holding register lets a new word arrive while the current word is still being sent, so words can stream back to back.

There are two mappings for the same four lines. In narrowband-pair mode, two independent complex channels (A and B) are carried together, and each line holds one component of one channel. In wideband mode, one complex channel uses all four lines. Its I and Q components are each sent two bits per bit time, so a word takes half as many bit times. The word length can be set to an even number from 8 to 24 bits. The mode and the length are both taken at a word boundary, so a setting changed in the middle of a word never disturbs that word.

Top module: `serial_out_fmt`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `ser_line` and `sync_out` are all zero.
- R2: In narrowband-pair mode (`mode_sel`=0), each bit time drives line 0 with channel-A I, line 1 with channel-B I, line 2 with channel-A Q and line 3 with channel-B Q. Bits go out one per bit time, MSB first, so a word of W bits takes W bit times.
- R3: In wideband mode (`mode_sel`=1), each bit time drives line 0 with I bit k, line 1 with I bit k-1, line 2 with Q bit k and line 3 with Q bit k-1. Bit k starts at W-1 and falls by two each bit time, so a word takes W/2 bit times. The channel-B inputs have no effect in this mode.
- R4: `sync_out` is high for exactly one bit time, in the same bit time as the first bit of each word, and is low at all other times.
- R5: A word is captured on the clock edge where `in_valid` is high. When the lines are idle, its first bit and `sync_out` appear after the following edge, two edges after capture.
- R6: When a word is waiting in the holding register, it starts in the bit time right after the last bit of the current word, with no gap.
- R7: If a word arrives while the holding register is occupied and the held word is not starting on that edge, the new word replaces the held one. The replaced word is never sent.
- R8: When no word is being sent, all four lines are zero.
- R9: `mode_sel` and `word_len` are sampled only when a word starts. Changing them during a word does not alter that word.
- R10: An input word is right-justified: only bits W-1..0 are used, and the upper bits are ignored. An odd `word_len` is rounded down to even. A value below 8 acts as 8, and a value above 24 acts as 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: parallel word present this cycle |
| mode_sel | input | 1 | 0 = narrowband pair, 1 = wideband |
| word_len | input | 5 | Word length in bits (even, 8..24) |
| in_ia | input | 24 | Channel A in-phase word |
| in_qa | input | 24 | Channel A quadrature word |
| in_ib | input | 24 | Channel B in-phase word |
| in_qb | input | 24 | Channel B quadrature word |
| ser_line | output | 4 | Serial data lines 0..3 |
| sync_out | output | 1 | Word-start mark |

## Verification
Two functions can land on the same clock edge. One is the start of a held word at the last bit of the current word. The other is the capture of a new incoming word, which can either refill the holding register as it empties or overwrite it while it is still full. The bench provokes both by strobing words on consecutive cycles while a word is in flight. The scoreboard then requires that the first word is followed with no gap by the newest word only, and that the overwritten word never shows up on the lines.

// File: rtl/sof_pkg.sv
// Shared definitions for the serial output formatter.
// Assumes four serial lines and four component words per parallel input.
package sof_pkg;
    typedef enum logic {
        FMT_PAIR = 1'b0,
        FMT_WIDE = 1'b1
    } fmt_mode_e;

    localparam int NUM_LANES = 4;
    localparam int LANE_IA   = 0;
    localparam int LANE_IB   = 1;
    localparam int LANE_QA   = 2;
    localparam int LANE_QB   = 3;
endpackage

// File: rtl/sof_hold_buf.sv
// One-entry holding register for parallel words.
// A write always wins over a take, so the newest word replaces an older one.
// Assumes that take is raised only while vld is high.
module sof_hold_buf #(
    parameter int DW = 96
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          take,
    output logic          vld,
    output logic [DW-1:0] rdata
);
    // Capture new data, or empty the entry when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld   <= 1'b0;
            rdata <= '0;
        end else if (wr) begin
            vld   <= 1'b1;
            rdata <= wdata;
        end else if (take) begin
            vld   <= 1'b0;
        end
    end
endmodule

// File: rtl/sof_seq.sv
// Word sequencer: counts the bit times of the current word and decides
// when the held word starts. It samples the mode and a clamped word length at
// that point. Assumes MIN_W >= 4, so a word never lasts a single bit time.
module sof_seq
    import sof_pkg::*;
#(
    parameter int MAX_W = 24,
    parameter int MIN_W = 8,
    localparam int LW = $clog2(MAX_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_vld,
    input  logic          mode_in,
    input  logic [LW-1:0] len_in,
    output logic          load,
    output logic          busy,
    output logic          first,
    output fmt_mode_e     mode_q,
    output logic [LW-1:0] len_eff,
    output logic [LW-1:0] cnt_q
);
    logic [LW-1:0] steps;
    logic          first_q;

    // Clamp the requested length into the even range MIN_W..MAX_W.
    always_comb begin
        if (len_in < LW'(MIN_W))
            len_eff = LW'(MIN_W);
        else if (len_in > LW'(MAX_W))
            len_eff = LW'(MAX_W);
        else
            len_eff = {len_in[LW-1:1], 1'b0};
        steps = (fmt_mode_e'(mode_in) == FMT_WIDE) ? (len_eff >> 1) : len_eff;
    end

    // Start the held word when idle or on the last bit of the current word.
    assign load  = hold_vld && (cnt_q <= LW'(1));
    assign busy  = (cnt_q != '0);
    assign first = first_q;

    // Count the remaining bit times and sample the mode at word start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mode_q  <= FMT_PAIR;
            first_q <= 1'b0;
        end else begin
            first_q <= load;
            if (load) begin
                cnt_q  <= steps;
                mode_q <= fmt_mode_e'(mode_in);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - LW'(1);
            end
        end
    end
endmodule

// File: rtl/sof_lane.sv
// Shift register for one component word. On load it left-aligns the
// right-justified input, which drops the bits above the word length. It then
// shifts one or two places per bit time. It shows its two top bits.
module sof_lane #(
    parameter int MAX_W = 24,
    localparam int LW = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift_en,
    input  logic             shift2,
    input  logic [LW-1:0]    len_eff,
    input  logic [MAX_W-1:0] din,
    output logic [1:0]       top2
);
    logic [MAX_W-1:0] sh_q;

    // Load an aligned word or advance by the per-mode bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= din << (LW'(MAX_W) - len_eff);
        end else if (shift_en) begin
            sh_q <= shift2 ? (sh_q << 2) : (sh_q << 1);
        end
    end

    assign top2 = sh_q[MAX_W-1:MAX_W-2];
endmodule

// File: rtl/serial_out_fmt.sv
// Dual-mode bit-serial output formatter (top).
// Accepts parallel I/Q words for two narrowband channels or one wideband
// channel and sends them MSB first on four lines with a word-start mark.
// Assumes one bit time per clock and a synchronous active-low reset.
module serial_out_fmt
    import sof_pkg::*;
#(
    parameter int MAX_W = 24,
    parameter int MIN_W = 8,
    localparam int LW = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode_sel,
    input  logic [LW-1:0]    word_len,
    input  logic [MAX_W-1:0] in_ia,
    input  logic [MAX_W-1:0] in_qa,
    input  logic [MAX_W-1:0] in_ib,
    input  logic [MAX_W-1:0] in_qb,
    output logic [3:0]       ser_line,
    output logic             sync_out
);
    localparam int DW = NUM_LANES * MAX_W;

    logic [DW-1:0]   pack_in;
    logic [DW-1:0]   hold_data;
    logic            hold_vld;
    logic            load;
    logic            busy;
    logic            first;
    fmt_mode_e       mode_q;
    logic [LW-1:0]   len_eff;
    logic [LW-1:0]   cnt_q;
    logic [1:0]      top2 [NUM_LANES];

    assign pack_in = {in_qb, in_qa, in_ib, in_ia};

    sof_hold_buf #(.DW(DW)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (in_valid),
        .wdata (pack_in),
        .take  (load),
        .vld   (hold_vld),
        .rdata (hold_data)
    );

    sof_seq #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_vld (hold_vld),
        .mode_in  (mode_sel),
        .len_in   (word_len),
        .load     (load),
        .busy     (busy),
        .first    (first),
        .mode_q   (mode_q),
        .len_eff  (len_eff),
        .cnt_q    (cnt_q)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sof_lane #(.MAX_W(MAX_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .shift_en (busy && !load),
            .shift2   (mode_q == FMT_WIDE),
            .len_eff  (len_eff),
            .din      (hold_data[g*MAX_W +: MAX_W]),
            .top2     (top2[g])
        );
    end

    // Map lane bits onto the four lines for the active mode; zero when idle.
    always_comb begin
        ser_line = 4'b0000;
        if (busy) begin
            if (mode_q == FMT_WIDE)
                ser_line = {top2[LANE_QA][0], top2[LANE_QA][1],
                            top2[LANE_IA][0], top2[LANE_IA][1]};
            else
                ser_line = {top2[LANE_QB][1], top2[LANE_QA][1],
                            top2[LANE_IB][1], top2[LANE_IA][1]};
        end
    end

    assign sync_out = first;
endmodule

// File: rtl/serial_out_fmt_chk.sv
// Property checker for serial_out_fmt, attached with bind.
// Observes the output ports, the bit-time counter, the sampled mode and the
// holding-register flag.
module serial_out_fmt_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    ser_line,
    input logic          sync_out,
    input logic [CW-1:0] cnt_q,
    input logic          mode_q,
    input logic          hold_vld
);
    // R4
    sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !sync_out);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> (ser_line == 4'b0000 && !sync_out));

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && cnt_q == '0) |=> sync_out);

    // R6
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && cnt_q == CW'(1)) |=> sync_out);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > CW'(1)) |=> $stable(mode_q));
endmodule

bind serial_out_fmt serial_out_fmt_chk #(.CW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_line (ser_line),
    .sync_out (sync_out),
    .cnt_q    (cnt_q),
    .mode_q   (mode_q),
    .hold_vld (hold_vld)
);

// File: tb/sim_serial_out_fmt.sv
// Scoreboard bench for serial_out_fmt.
module sim_serial_out_fmt;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode_sel = 1'b0;
    logic [4:0]  word_len = 5'd8;
    logic [23:0] ia = '0, qa = '0, ib = '0, qb = '0;
    logic [3:0]  ser_line;
    logic        sync_out;

    typedef struct {
        logic [3:0] lines;
        logic       sync;
        int         nsteps;
        string      req;
    } item_t;

    item_t exp_q[$];
    int n_chk = 0, n_bad = 0, cyc = 0, rem = 0;
    int last_sync = -1, prev_sync = -1, d = 0;
    bit done = 1'b0;

    serial_out_fmt u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
        .word_len(word_len), .in_ia(ia), .in_qa(qa), .in_ib(ib), .in_qb(qb),
        .ser_line(ser_line), .sync_out(sync_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_len(int l);
        if (l < 8) return 8;
        if (l > 24) return 24;
        return l - (l % 2);
    endfunction

    // Driver side: compute the expected bit times of one word.
    task automatic expect_word(logic [23:0] a_i, logic [23:0] a_q,
                               logic [23:0] b_i, logic [23:0] b_q,
                               bit wide, int len, string req);
        int L;
        int steps;
        int b;
        item_t it;
        L = eff_len(len);
        steps = wide ? L / 2 : L;
        for (int k = 0; k < steps; k++) begin
            if (wide) begin
                b = L - 1 - 2 * k;
                it.lines = {a_q[b-1], a_q[b], a_i[b-1], a_i[b]};
            end else begin
                b = L - 1 - k;
                it.lines = {b_q[b], a_q[b], b_i[b], a_i[b]};
            end
            it.sync = (k == 0);
            it.nsteps = steps;
            it.req = req;
            exp_q.push_back(it);
        end
    endtask

    // Present one word for one cycle; called at a falling edge.
    task automatic push(logic [23:0] a_i, logic [23:0] a_q,
                        logic [23:0] b_i, logic [23:0] b_q);
        ia = a_i; qa = a_q; ib = b_i; qb = b_q;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pop and compare during words, require zero lines when idle.
    always @(negedge clk) begin
        item_t it;
        if (rst_n && !done) begin
            if (sync_out) begin
                prev_sync = last_sync;
                last_sync = cyc;
            end
            if (rem == 0 && !sync_out) begin
                chk(ser_line == 4'b0, "R8", "idle lines", ser_line, 0);
            end else if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected output", {sync_out, ser_line}, 0);
            end else begin
                it = exp_q.pop_front();
                chk(ser_line == it.lines && sync_out == it.sync, it.req,
                    "bit time", {sync_out, ser_line}, {it.sync, it.lines});
                rem = it.sync ? it.nsteps - 1 : rem - 1;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ser_line == 4'b0, "R1", "lines in reset", ser_line, 0);
        chk(sync_out == 1'b0, "R1", "sync in reset", sync_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_line == 4'b0 && !sync_out, "R1", "after reset", ser_line, 0);

        // R2 and R5: narrowband pair word from idle
        mode_sel = 1'b0; word_len = 5'd8;
        expect_word(24'hA5, 24'hF0, 24'h3C, 24'h0F, 1'b0, 8, "R2");
        d = cyc;
        push(24'hA5, 24'hF0, 24'h3C, 24'h0F);
        repeat (20) @(negedge clk);
        chk(last_sync == d + 2, "R5", "first-bit cycle", last_sync, d + 2);

        // R3: wideband, channel B inputs must not matter
        mode_sel = 1'b1; word_len = 5'd16;
        expect_word(24'hC3A5, 24'h5A0F, 24'hFFFF, 24'hFFFF, 1'b1, 16, "R3");
        push(24'hC3A5, 24'h5A0F, 24'hFFFF, 24'hFFFF);
        repeat (20) @(negedge clk);

        // R6: two consecutive words stream without a gap
        mode_sel = 1'b0; word_len = 5'd8;
        expect_word(24'h81, 24'h42, 24'h24, 24'h18, 1'b0, 8, "R6");
        expect_word(24'h7E, 24'hBD, 24'hDB, 24'hE7, 1'b0, 8, "R6");
        push(24'h81, 24'h42, 24'h24, 24'h18);
        push(24'h7E, 24'hBD, 24'hDB, 24'hE7);
        repeat (30) @(negedge clk);
        chk(last_sync - prev_sync == 8, "R6", "word spacing", last_sync - prev_sync, 8);

        // R7: the third word overwrites the held second word
        expect_word(24'h11, 24'h22, 24'h33, 24'h44, 1'b0, 8, "R7");
        expect_word(24'hC6, 24'h9A, 24'h35, 24'h6C, 1'b0, 8, "R7");
        push(24'h11, 24'h22, 24'h33, 24'h44);
        push(24'hEE, 24'hDD, 24'hCC, 24'hBB);
        push(24'hC6, 24'h9A, 24'h35, 24'h6C);
        repeat (40) @(negedge clk);
        chk(last_sync - prev_sync == 8, "R7", "replacement spacing", last_sync - prev_sync, 8);

        // R9: mode changes while a word is being sent
        mode_sel = 1'b0; word_len = 5'd8;
        expect_word(24'hB4, 24'h2D, 24'h96, 24'h69, 1'b0, 8, "R9");
        expect_word(24'h5C, 24'hA3, 24'h00, 24'h00, 1'b1, 8, "R9");
        push(24'hB4, 24'h2D, 24'h96, 24'h69);
        @(negedge clk);
        mode_sel = 1'b1;
        push(24'h5C, 24'hA3, 24'hFF, 24'hFF);
        repeat (30) @(negedge clk);
        chk(last_sync - prev_sync == 8, "R9", "first word kept its mode", last_sync - prev_sync, 8);

        // R10: right-justified with junk above W, and length clamping
        mode_sel = 1'b0; word_len = 5'd12;
        expect_word(24'hFFF5A3, 24'hABC3C5, 24'h123A5A, 24'hFED0F1, 1'b0, 12, "R10");
        push(24'hFFF5A3, 24'hABC3C5, 24'h123A5A, 24'hFED0F1);
        repeat (30) @(negedge clk);
        word_len = 5'd13;
        expect_word(24'h000ACE, 24'h000531, 24'h000777, 24'h000888, 1'b0, 13, "R10");
        push(24'h000ACE, 24'h000531, 24'h000777, 24'h000888);
        repeat (30) @(negedge clk);
        mode_sel = 1'b1; word_len = 5'd30;
        expect_word(24'h9D3B71, 24'h2468AC, 24'h0, 24'h0, 1'b1, 30, "R10");
        push(24'h9D3B71, 24'h2468AC, 24'h0, 24'h0);
        repeat (30) @(negedge clk);
        word_len = 5'd2;
        expect_word(24'h0000B7, 24'h00004E, 24'h0, 24'h0, 1'b1, 2, "R10");
        push(24'h0000B7, 24'h00004E, 24'h0, 24'h0);
        repeat (20) @(negedge clk);

        chk(exp_q.size() == 0, "R7", "all expected words sent", exp_q.size(), 0);
        done = 1'b1;
        summary();
    end
endmodule